// File: doc/BRIEF.md
# Multi-Level Lookahead Binary Adder

This block adds two unsigned operands and a carry-in in one combinational pass. Nothing ripples from one 4-bit group to the next. Each bit first forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). Lookahead units then fold four such pairs into one group pair, level by level, until a single pair describes the whole word.

On the way back down, each unit turns the carry into its span into the carries for its four children. It uses flat sum-of-products equations. As a result, the carry into every group and every bit comes straight from lookahead logic and never from a neighbouring group's output. The width is a parameter. A 16-bit instance has two lookahead levels and a 64-bit instance has three. Logic depth grows with the number of levels, not with the width.

The word-level generate and propagate are brought out. A wider adder can use this block as one group of a further lookahead level.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, with all values taken as unsigned.
- R2: `cout` equals bit WIDTH of the (WIDTH+1)-bit unsigned value `a + b + cin`.
- R3: `grp_p` is 1 exactly when, at every bit position, one operand bit is 1 and the other is 0 (that is, `a ^ b` is all ones).
- R4: `grp_g` is 1 exactly when `a + b` with no carry-in exceeds 2^WIDTH - 1, so the word produces a carry whatever `cin` is.
- R5: `cout` equals `grp_g | (grp_p & cin)` for every input.
- R6: When `a ^ b` is all ones, `cin` crosses the whole word: every `sum` bit equals `~cin` and `cout` equals `cin`.
- R7: A carry produced at any bit k crosses any run of propagating bits above it, across 4-bit, 16-bit and 64-bit group boundaries alike. With `a = 1 << k` and `b` holding ones from bit k upward, `sum` is 0 and `cout` is 1.
- R8: WIDTH may be 16 or 64. Both widths meet R1 to R7. The 16-bit form uses two lookahead levels and the 64-bit form uses three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the result |
| cout | output | 1 | Carry out of the top bit |
| grp_g | output | 1 | The whole word generates a carry |
| grp_p | output | 1 | The whole word propagates its carry-in |

## Verification
The block has no latency, so a wrong carry at any level shows on `sum` in the same evaluation in which the operands change. The error appears at the first bit of the child group whose carry-in was wrong, and it can flip every bit up to the next generating or killing position. A faulty group generate or propagate term at the top level shows at once on `grp_g`, `grp_p` and `cout`. The walking-carry patterns of R7 put the only carry source at each bit position in turn, so a carry equation that is missing or mis-indexed at any level produces a nonzero `sum` for some k.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Radix of the lookahead tree: each unit combines this many children.
    localparam int RADIX = 4;

    // Generate / propagate pair carried through the tree.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Number of radix-4 levels needed to cover n bits (n is a power of 4).
    function automatic int levels_for(input int n);
        int r;
        int v;
        r = 0;
        v = n;
        while (v > 1) begin
            v = v / RADIX;
            r = r + 1;
        end
        return r;
    endfunction

    // Start of tree level lvl in the flat node array (level 0 = per-bit nodes).
    function automatic int level_base(input int width, input int lvl);
        int acc;
        acc = 0;
        for (int i = 0; i < lvl; i++) begin
            acc = acc + (width >> (2 * i));
        end
        return acc;
    endfunction

    // Total node count over levels 0 .. levels_for(width).
    function automatic int node_total(input int width);
        return level_base(width, levels_for(width) + 1);
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
    parameter int N = 16
) (
    input  logic [N-1:0]         a,
    input  logic [N-1:0]         b,
    output cla_pkg::gp_t [N-1:0] gp_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign gp_o[i].g = a[i] & b[i];
        assign gp_o[i].p = a[i] ^ b[i];
    end
endmodule

// File: rtl/cla_lcu.sv
module cla_lcu (
    input  cla_pkg::gp_t [3:0] gp_i,
    input  logic               c_i,
    output logic [3:1]         c_o,
    output cla_pkg::gp_t       grp_o
);
    logic [3:0] g;
    logic [3:0] p;

    for (genvar j = 0; j < 4; j++) begin : g_split
        assign g[j] = gp_i[j].g;
        assign p[j] = gp_i[j].p;
    end

    // Flat two-level carries into children 1..3.
    assign c_o[1] = g[0] | (p[0] & c_i);
    assign c_o[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_i);
    assign c_o[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                  | (p[2] & p[1] & p[0] & c_i);

    // Summary pair for the parent level.
    assign grp_o.g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0]);
    assign grp_o.p = p[3] & p[2] & p[1] & p[0];

    always_comb begin
        // R6
        all_prop_chk: assert (!grp_o.p || (c_o == {3{c_i}}))
            else $error("lookahead unit: full propagate but carries differ from carry-in");
        for (int j = 1; j < 4; j++) begin
            // R7
            kill_gen_chk: assert (p[j-1] || (c_o[j] == g[j-1]))
                else $error("lookahead unit: non-propagating child %0d lost its own generate", j - 1);
        end
    end
endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
    parameter int N = 16
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] c,
    output logic [N-1:0] s
);
    for (genvar i = 0; i < N; i++) begin : g_xor
        assign s[i] = p[i] ^ c[i];
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             grp_g,
    output logic             grp_p
);
    import cla_pkg::*;

    localparam int LEVELS = levels_for(WIDTH);
    localparam int TOTAL  = node_total(WIDTH);
    localparam int TOP    = level_base(WIDTH, LEVELS);

    if (WIDTH != (1 << (2 * LEVELS)) || LEVELS < 2) begin : g_bad_width
        $error("cla_adder: WIDTH must be 16 or 64");
    end

    gp_t [TOTAL-1:0] node;
    logic [WIDTH:0]   c;
    logic [WIDTH-1:0] p_bits;

    // Level 0: per-bit generate / propagate.
    cla_bit_gp #(.N(WIDTH)) u_bit_gp (
        .a    (a),
        .b    (b),
        .gp_o (node[WIDTH-1:0])
    );

    // Levels 1..LEVELS: lookahead units. Unit k at level l spans 4^l bits.
    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        localparam int NUNITS = WIDTH >> (2 * l);
        localparam int CHILD  = 1 << (2 * (l - 1));
        localparam int IN_B   = level_base(WIDTH, l - 1);
        localparam int OUT_B  = level_base(WIDTH, l);
        for (genvar k = 0; k < NUNITS; k++) begin : g_unit
            localparam int BASE = k * CHILD * 4;
            logic [3:1] cc;
            cla_lcu u_lcu (
                .gp_i  (node[IN_B + 4*k + 3 : IN_B + 4*k]),
                .c_i   (c[BASE]),
                .c_o   (cc),
                .grp_o (node[OUT_B + k])
            );
            for (genvar j = 1; j < 4; j++) begin : g_cout
                assign c[BASE + j*CHILD] = cc[j];
            end
        end
    end

    assign c[0]     = cin;
    assign grp_g    = node[TOP].g;
    assign grp_p    = node[TOP].p;
    assign c[WIDTH] = grp_g | (grp_p & cin);
    assign cout     = c[WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_pbits
        assign p_bits[i] = node[i].p;
    end

    cla_sum #(.N(WIDTH)) u_sum (
        .p (p_bits),
        .c (c[WIDTH-1:0]),
        .s (sum)
    );

    always_comb begin
        // R1 R2
        result_chk: assert ({cout, sum} ==
                            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("cla_adder: result differs from arithmetic sum");
        // R6
        full_prop_chk: assert (!grp_p || ((sum == {WIDTH{~cin}}) && (cout == cin)))
            else $error("cla_adder: full propagate did not pass carry-in across word");
    end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
    localparam int W  = 64;
    localparam int WS = 16;

    typedef struct {
        logic [W-1:0]  s64;
        logic          c64;
        logic          g64;
        logic          p64;
        logic [WS-1:0] s16;
        logic          c16;
        logic          g16;
        logic          p16;
        logic          ci;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0]  a, b;
    logic          cin;
    logic [W-1:0]  sum;
    logic          cout, grp_g, grp_p;
    logic [WS-1:0] sum16;
    logic          cout16, grp_g16, grp_p16;

    cla_adder #(.WIDTH(W)) u_dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_g(grp_g), .grp_p(grp_p)
    );

    cla_adder #(.WIDTH(WS)) u_dut16 (
        .a(a[WS-1:0]), .b(b[WS-1:0]), .cin(cin), .sum(sum16), .cout(cout16),
        .grp_g(grp_g16), .grp_p(grp_p16)
    );

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic ci, input string tag);
        exp_t e;
        logic [W:0]  r64, g64;
        logic [WS:0] r16, g16;
        @(posedge clk);
        #1;
        a = av; b = bv; cin = ci;
        r64 = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, ci};
        g64 = {1'b0, av} + {1'b0, bv};
        r16 = {1'b0, av[WS-1:0]} + {1'b0, bv[WS-1:0]} + {{WS{1'b0}}, ci};
        g16 = {1'b0, av[WS-1:0]} + {1'b0, bv[WS-1:0]};
        e.s64 = r64[W-1:0];  e.c64 = r64[W];  e.g64 = g64[W];  e.p64 = &(av ^ bv);
        e.s16 = r16[WS-1:0]; e.c16 = r16[WS]; e.g16 = g16[WS];
        e.p16 = &(av[WS-1:0] ^ bv[WS-1:0]);
        e.ci  = ci;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares half a period after each drive.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({"R1 ", e.tag}, "sum64", {1'b0, sum}, {1'b0, e.s64});
                chk({"R2 ", e.tag}, "cout64", {{W{1'b0}}, cout}, {{W{1'b0}}, e.c64});
                chk({"R4 ", e.tag}, "grp_g64", {{W{1'b0}}, grp_g}, {{W{1'b0}}, e.g64});
                chk({"R3 ", e.tag}, "grp_p64", {{W{1'b0}}, grp_p}, {{W{1'b0}}, e.p64});
                chk({"R5 ", e.tag}, "cout64_vs_grp", {{W{1'b0}}, cout},
                    {{W{1'b0}}, grp_g | (grp_p & e.ci)});
                // R8: the 16-bit form meets the same rules.
                chk({"R8 ", e.tag}, "sum16", {{(W-WS){1'b0}}, 1'b0, sum16},
                    {{(W-WS){1'b0}}, 1'b0, e.s16});
                chk({"R8 ", e.tag}, "cout16", {{W{1'b0}}, cout16}, {{W{1'b0}}, e.c16});
                chk({"R8 ", e.tag}, "grp_g16", {{W{1'b0}}, grp_g16}, {{W{1'b0}}, e.g16});
                chk({"R8 ", e.tag}, "grp_p16", {{W{1'b0}}, grp_p16}, {{W{1'b0}}, e.p16});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        // Quiet start: zero operands.
        drive('0, '0, 1'b0, "zero");
        // R2 R6: full propagate with carry-in wraps to zero.
        drive('1, '0, 1'b1, "R6 ones+cin");
        drive('1, '0, 1'b0, "R6 ones no cin");
        drive('1, '1, 1'b1, "R4 ones+ones");
        drive({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b0, "R6 alt0");
        drive({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b1, "R6 alt1");
        drive({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, "R4 top gen");
        // R7: walking generate with a propagate chain above it.
        for (int k = 0; k < W; k++) begin
            drive(W'(1) << k, {W{1'b1}} << k, 1'b0, "R7 walk");
        end
        // R7: carry-in walks through a propagate run that ends at bit k.
        for (int k = 1; k < W; k++) begin
            drive({W{1'b1}} >> (W - k), '0, 1'b1, "R7 run");
        end
        // R1 R2: random operands.
        for (int n = 0; n < 400; n++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "random");
        end
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule